// File: doc/BRIEF.md
# Auxiliary-Channel Request Framer

This block turns one auxiliary-channel request (a 20-bit target address, a 4-bit command and a payload length) into the byte sequence that a link-layer serializer transmits. It first checks the request. If the command is not a known read or write class, or the length is over the limit for that class, the request is refused with a one-cycle reject pulse and no bytes are sent. An accepted request is sent as a four-byte header. For a write, the payload bytes follow the header. The payload is taken from a flat buffer that is captured when the request is accepted. Bytes leave on a valid/ready interface, and the final byte of each frame carries a last marker.

The block also reads the status byte that the link layer returns at the end of a transaction. Three status values abort the transaction: timeout, nonzero flags and general error. In any other case the block reports the reply code from the top nibble of the status byte, and a received byte count that is limited to what the request asked for.

Top module: `aux_hdr_packer`

## Requirements
- R1: Header byte 0 is addr[7:0]. Header byte 1 is addr[15:8]. Header byte 2 is {cmd, addr[19:16]}. The bytes are sent in the order 0, 1, 2, 3.
- R2: The low nibble of header byte 3 is len-1, or 0 when len is 0.
- R3: The high nibble of header byte 3 depends on the request. A zero-length request gives 3. A nonzero read gives 4. A nonzero write gives (4+len) modulo 16, so a 12-byte write gives 0.
- R4: A read frame has exactly 4 bytes. A write frame has 4+len bytes, and payload byte k is wr_buf[8k+7:8k]. out_last is high on the final byte only.
- R5: A request with len > 16 is refused, and so is a write-class request with len > 12. The refusal is a pulse on rej_len one cycle after start, and no byte is sent.
- R6: Command bit 2 is ignored when the request is classified. With that bit cleared, codes 0, 2 and 8 are writes and codes 1 and 9 are reads. Any other code raises rej_cmd and sends no byte. A length refusal takes precedence over a command refusal.
- R7: A start that arrives while a frame is being sent is ignored. The frame in progress is not changed, and no second frame follows it.
- R8: While out_valid is high and out_ready is low, out_data and out_last hold their values.
- R9: Status value 0x01 sets res_timeout, 0x02 sets res_flag and 0x03 sets res_err. In each of these cases res_count is 0. The results appear with res_valid one cycle after stat_valid.
- R10: res_reply is the upper nibble of the status byte. For a non-aborting status, res_count is as follows. After a read it is min(rx_count, requested len). After a write it is the requested len.
- R11: After reset, out_valid, busy, rej_len, rej_cmd and res_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe |
| addr | input | 20 | Target address |
| cmd | input | 4 | Request command |
| len | input | 5 | Payload length in bytes |
| wr_buf | input | 96 | Write payload, byte k in bits 8k+7:8k |
| busy | output | 1 | Frame in progress |
| rej_len | output | 1 | Length refusal pulse |
| rej_cmd | output | 1 | Command refusal pulse |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| stat_valid | input | 1 | Status byte strobe |
| stat_byte | input | 8 | Returned status byte |
| rx_count | input | 5 | Bytes returned by the link |
| res_valid | output | 1 | Decoded result strobe |
| res_timeout | output | 1 | Timeout abort |
| res_flag | output | 1 | Nonzero-flags abort |
| res_err | output | 1 | General error abort |
| res_reply | output | 4 | Reply code |
| res_count | output | 5 | Reported byte count |

## Verification
The hardest case to reach from the ports is a start that collides with a frame still being sent. The bench starts a write and holds out_ready low for several cycles, so the frame is stalled at its first byte. While it is stalled, the bench applies a second start with a different address and command. The bench then lets the frame drain and checks two things: every byte still belongs to the first request, and out_valid stays low after the last byte. Count clipping can only be seen when a decoded status follows an accepted read, so the bench puts a read request in front of each status case that depends on the clip.

// File: rtl/aux_hdr_packer.sv
module aux_hdr_packer #(
  parameter int RD_MAX = 16,
  parameter int WR_MAX = 12,
  localparam int HDR   = 4,
  localparam int LW    = $clog2(RD_MAX + 1),
  localparam int CW    = $clog2(HDR + RD_MAX + 1),
  localparam int PIW   = $clog2(WR_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [19:0]       addr,
  input  logic [3:0]        cmd,
  input  logic [LW-1:0]     len,
  input  logic [WR_MAX*8-1:0] wr_buf,
  output logic              busy,
  output logic              rej_len,
  output logic              rej_cmd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  input  logic              stat_valid,
  input  logic [7:0]        stat_byte,
  input  logic [LW-1:0]     rx_count,
  output logic              res_valid,
  output logic              res_timeout,
  output logic              res_flag,
  output logic              res_err,
  output logic [3:0]        res_reply,
  output logic [LW-1:0]     res_count
);

  logic [3:0] cls;
  logic       is_wr, is_rd, too_long, go, accept;
  logic [3:0] lo_nib, hi_nib;

  assign cls      = cmd & 4'b1011;
  assign is_wr    = (cls == 4'd0) || (cls == 4'd2) || (cls == 4'd8);
  assign is_rd    = (cls == 4'd1) || (cls == 4'd9);
  assign too_long = (len > LW'(RD_MAX)) || (is_wr && (len > LW'(WR_MAX)));
  assign go       = start && !busy;
  assign accept   = go && !too_long && (is_wr || is_rd);
  assign lo_nib   = (len == '0) ? 4'd0 : 4'(len - 1'b1);
  assign hi_nib   = (len == '0) ? 4'd3 : (is_rd ? 4'(HDR) : 4'(HDR + len));

  logic [7:0]    hdr [HDR];
  logic [7:0]    pay [WR_MAX];
  logic [CW-1:0] idx, nbytes;
  logic [LW-1:0] req_len;
  logic          req_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rej_len <= 1'b0;
      rej_cmd <= 1'b0;
      idx     <= '0;
      nbytes  <= '0;
      req_len <= '0;
      req_rd  <= 1'b0;
      for (int i = 0; i < HDR; i++) hdr[i] <= '0;
      for (int i = 0; i < WR_MAX; i++) pay[i] <= '0;
    end else begin
      rej_len <= go && too_long;
      rej_cmd <= go && !too_long && !(is_wr || is_rd);
      if (accept) begin
        busy    <= 1'b1;
        idx     <= '0;
        nbytes  <= is_rd ? CW'(HDR) : CW'(HDR + len);
        req_len <= len;
        req_rd  <= is_rd;
        hdr[0]  <= addr[7:0];
        hdr[1]  <= addr[15:8];
        hdr[2]  <= {cmd, addr[19:16]};
        hdr[3]  <= {hi_nib, lo_nib};
        for (int i = 0; i < WR_MAX; i++) pay[i] <= wr_buf[8*i +: 8];
      end else if (busy && out_ready) begin
        if (out_last) busy <= 1'b0;
        else          idx  <= idx + 1'b1;
      end
    end
  end

  logic [CW-1:0] pidx;
  assign pidx      = idx - CW'(HDR);
  assign out_valid = busy;
  assign out_last  = busy && (idx == nbytes - 1'b1);
  assign out_data  = (idx < CW'(HDR)) ? hdr[idx[1:0]] : pay[pidx[PIW-1:0]];

  logic abort;
  assign abort = (stat_byte == 8'd1) || (stat_byte == 8'd2) || (stat_byte == 8'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_timeout <= 1'b0;
      res_flag    <= 1'b0;
      res_err     <= 1'b0;
      res_reply   <= '0;
      res_count   <= '0;
    end else begin
      res_valid <= stat_valid;
      if (stat_valid) begin
        res_timeout <= stat_byte == 8'd1;
        res_flag    <= stat_byte == 8'd2;
        res_err     <= stat_byte == 8'd3;
        res_reply   <= stat_byte[7:4];
        if (abort)       res_count <= '0;
        else if (req_rd) res_count <= (rx_count > req_len) ? req_len : rx_count;
        else             res_count <= req_len;
      end
    end
  end

endmodule

// File: rtl/aux_hdr_packer_chk.sv
module aux_hdr_packer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       rej_len,
  input logic       rej_cmd,
  input logic       res_valid,
  input logic       res_timeout,
  input logic       res_flag,
  input logic       res_err,
  input logic [4:0] res_count
);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  p_frame_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  p_len_reject_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rej_len |-> !out_valid && !rej_cmd);

  p_cmd_reject_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rej_cmd |-> !out_valid);

  p_abort_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_timeout || res_flag || res_err) |-> res_count == 5'd0);

  p_abort_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0({res_timeout, res_flag, res_err}));

endmodule

bind aux_hdr_packer aux_hdr_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .rej_len(rej_len), .rej_cmd(rej_cmd),
  .res_valid(res_valid), .res_timeout(res_timeout), .res_flag(res_flag),
  .res_err(res_err), .res_count(res_count)
);

// File: tb/aux_hdr_packer_bench.sv
module aux_hdr_packer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  // {addr[20], cmd[4], len[5], b3[8], nbytes[5], rej[2]}  rej: 0 ok, 1 length, 2 command
  localparam logic [43:0] VEC [NV] = '{
    {20'h12345, 4'h9, 5'd16, 8'h4F, 5'd4,  2'd0},
    {20'hABCDE, 4'h8, 5'd3,  8'h72, 5'd7,  2'd0},
    {20'h00001, 4'h8, 5'd0,  8'h30, 5'd4,  2'd0},
    {20'hF0F0F, 4'h1, 5'd0,  8'h30, 5'd4,  2'd0},
    {20'h5A5A5, 4'h0, 5'd12, 8'h0B, 5'd16, 2'd0},
    {20'h11111, 4'h8, 5'd13, 8'h00, 5'd0,  2'd1},
    {20'h22222, 4'h9, 5'd17, 8'h00, 5'd0,  2'd1},
    {20'h33333, 4'h3, 5'd2,  8'h00, 5'd0,  2'd2},
    {20'h44444, 4'h5, 5'd1,  8'h40, 5'd4,  2'd0},
    {20'h55555, 4'h6, 5'd1,  8'h50, 5'd5,  2'd0},
    {20'h66666, 4'h4, 5'd2,  8'h61, 5'd6,  2'd0},
    {20'h77777, 4'hA, 5'd1,  8'h00, 5'd0,  2'd2},
    {20'h88888, 4'hF, 5'd20, 8'h00, 5'd0,  2'd1},
    {20'h99999, 4'hC, 5'd1,  8'h50, 5'd5,  2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, out_ready = 1'b1, stat_valid = 1'b0;
  logic [19:0] addr = '0;
  logic [3:0]  cmd = '0;
  logic [4:0]  len = '0, rx_count = '0;
  logic [95:0] wr_buf;
  logic [7:0]  stat_byte = '0;
  logic busy, rej_len, rej_cmd, out_valid, out_last;
  logic [7:0] out_data;
  logic res_valid, res_timeout, res_flag, res_err;
  logic [3:0] res_reply;
  logic [4:0] res_count;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_hdr_packer u_aux_hdr_packer (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .cmd(cmd), .len(len),
    .wr_buf(wr_buf), .busy(busy), .rej_len(rej_len), .rej_cmd(rej_cmd),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .stat_valid(stat_valid), .stat_byte(stat_byte),
    .rx_count(rx_count), .res_valid(res_valid), .res_timeout(res_timeout),
    .res_flag(res_flag), .res_err(res_err), .res_reply(res_reply), .res_count(res_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [19:0] a, input logic [3:0] c, input logic [4:0] l);
    @(negedge clk);
    addr = a; cmd = c; len = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [7:0] exp_byte(input logic [19:0] a, input logic [3:0] c,
                                          input logic [7:0] b3, input int k);
    case (k)
      0: return a[7:0];
      1: return a[15:8];
      2: return {c, a[19:16]};
      3: return b3;
      default: return 8'hA0 + 8'(k - 4);
    endcase
  endfunction

  task automatic collect(input logic [19:0] a, input logic [3:0] c, input logic [7:0] b3,
                         input int n, input string tag);
    int got = 0;
    for (int it = 0; it < 40 && out_valid; it++) begin
      if (got < n) check({tag, " byte"}, out_data, exp_byte(a, c, b3, got));
      check({tag, " last R4"}, out_last, (got == n - 1));
      got++;
      @(negedge clk);
    end
    check({tag, " count R4"}, got, n);
  endtask

  task automatic status(input logic [7:0] s, input logic [4:0] rc);
    @(negedge clk);
    stat_byte = s; rx_count = rc; stat_valid = 1'b1;
    @(negedge clk);
    stat_valid = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 12; k++) wr_buf[8*k +: 8] = 8'hA0 + 8'(k);
    repeat (2) @(negedge clk);
    check("R11 out_valid", out_valid, 0);
    check("R11 busy", busy, 0);
    check("R11 rej", {rej_len, rej_cmd}, 0);
    check("R11 res_valid", res_valid, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [19:0] a; logic [3:0] c; logic [4:0] l, n; logic [7:0] b3; logic [1:0] rj;
      {a, c, l, b3, n, rj} = VEC[v];
      issue(a, c, l);
      check("R5 rej_len", rej_len, rj == 2'd1);
      check("R6 rej_cmd", rej_cmd, rj == 2'd2);
      collect(a, c, b3, int'(n), "R1 R2 R3 vec");
    end

    // R7 and R8: stalled frame, second start during busy
    out_ready = 1'b0;
    issue(20'hC0DE1, 4'h8, 5'd2);
    for (int i = 0; i < 3; i++) begin
      check("R8 stalled data", out_data, 8'hE1);
      check("R8 stalled valid", out_valid, 1);
      if (i == 1) begin
        addr = 20'h01234; cmd = 4'h9; len = 5'd4; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b1;
    collect(20'hC0DE1, 4'h8, 8'h61, 6, "R7 busy start");
    check("R7 no second frame", out_valid, 0);

    // R9 R10 status decode
    issue(20'h00010, 4'h9, 5'd5);
    collect(20'h00010, 4'h9, 8'h44, 4, "R10 rd5");
    status(8'h01, 5'd5);
    check("R9 timeout", {res_valid, res_timeout, res_flag, res_err}, 4'b1100);
    check("R9 timeout count", res_count, 0);
    status(8'h02, 5'd5);
    check("R9 flags", {res_valid, res_timeout, res_flag, res_err}, 4'b1010);
    check("R9 flags count", res_count, 0);
    status(8'h03, 5'd5);
    check("R9 err", {res_valid, res_timeout, res_flag, res_err}, 4'b1001);
    check("R9 err count", res_count, 0);
    status(8'h10, 5'd9);
    check("R10 clip count", res_count, 5);
    check("R10 reply", res_reply, 4'h1);
    check("R10 no abort", {res_timeout, res_flag, res_err}, 0);
    status(8'h20, 5'd3);
    check("R10 short count", res_count, 3);
    check("R10 reply2", res_reply, 4'h2);
    issue(20'h00020, 4'h8, 5'd3);
    collect(20'h00020, 4'h8, 8'h72, 7, "R10 wr3");
    status(8'h00, 5'd0);
    check("R10 write count", res_count, 3);
    @(negedge clk);
    check("R9 res_valid pulse", res_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule